// File: doc/BRIEF.md
# Snoop-Cancelled Load Reservation Tracker

This block keeps the single reservation that a data cache uses to pair load-reserve with store-conditional. A load-reserve enters in pipeline cycle 0 with its cache index and way. Its real address arrives during cycle 1, together with a non-cacheable flag, and is latched at the end of that cycle. The cycle after cycle 0 is always cycle 1. The reservation becomes valid on the first data-available strobe after that. Stores made by other bus agents arrive on a snoop port, which gives the index, way and real address of each one. Any snooped store to the reserved cache line cancels the reservation.

Two race windows exist before the real address is known. A snoop during cycle 0 is matched on cache index and way, and a match stops the pending reservation at the end of cycle 1. A snoop during cycle 1 is held for one cycle and compared against the newly latched line in cycle 2. After that, every cycle compares the reserved line with both the current snoop and the previous one.

A store-conditional is started by a request pulse. If the reservation is intact the request waits for the bus acknowledge, and the store passes. If the reservation is lost while the store waits, an abort is raised in the same cycle so that the bus master drops its cycle and strobe, and the store fails. A load-reserve or store-conditional marked non-cacheable raises a data storage exception and leaves the reservation untouched.

Top module: `resv_tracker`

## Requirements
- R1: After reset `resv_valid`, `sc_done`, `sc_pass`, `dsi` and `sc_abort` are all 0.
- R2: A cacheable load-reserve latches its line at the end of cycle 1 and becomes pending. `resv_valid` rises only on the edge that samples the first `lr_data_valid` of a pending reservation. Later strobes have no effect, so a quadword load-reserve becomes valid on its first doubleword.
- R3: A snoop in cycle 0 whose index and way both equal the load-reserve's index and way prevents the reservation from becoming valid. A snoop that differs in way does not.
- R4: A snoop whose line matches the reserved line clears a pending or valid reservation on the edge that samples it, and again on the following edge from the held copy. This covers a snoop made in cycle 1.
- R5: Line comparison ignores the low `LINE_OFF` address bits (64-byte lines by default). A snoop to another line keeps the reservation.
- R6: A store-conditional request (`sc_req`, not non-cacheable) made while `resv_valid` is 1 and its line equals the reserved line waits for `sc_ack`. The cycle after the acknowledge shows `sc_done`=1, `sc_pass`=1 and `resv_valid`=0.
- R7: A store-conditional request with no valid reservation, or with a different line, gives `sc_done`=1 and `sc_pass`=0 in the next cycle and clears the reservation.
- R8: If the reservation is lost while a store-conditional waits, `sc_abort` is 1 combinationally in that same cycle. The next cycle shows `sc_done`=1, `sc_pass`=0 and `resv_valid`=0.
- R9: A non-cacheable load-reserve pulses `dsi` in the cycle after its cycle 1. A non-cacheable store-conditional pulses `dsi` in the cycle after its request, without `sc_done`. In both cases the existing reservation, with its line, is kept.
- R10: A new cacheable load-reserve replaces the reserved line, so snoops to the old line no longer affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_c0_valid | input | 1 | Load-reserve in pipeline cycle 0 |
| lr_c0_index | input | IDX_W | Cache index of the load-reserve |
| lr_c0_way | input | WAY_W | Cache way of the load-reserve |
| lr_c1_addr | input | ADDR_W | Real address, valid in cycle 1 |
| lr_c1_nc | input | 1 | Load-reserve target is non-cacheable (cycle 1) |
| lr_data_valid | input | 1 | Load data available strobe |
| snp_valid | input | 1 | Store by another agent observed |
| snp_index | input | IDX_W | Cache index of the snooped store |
| snp_way | input | WAY_W | Cache way of the snooped store |
| snp_addr | input | ADDR_W | Real address of the snooped store |
| sc_req | input | 1 | Store-conditional start pulse |
| sc_addr | input | ADDR_W | Real address of the store-conditional |
| sc_nc | input | 1 | Store-conditional target is non-cacheable |
| sc_ack | input | 1 | Bus has accepted the store-conditional write |
| resv_valid | output | 1 | Reservation is held |
| sc_abort | output | 1 | Drop the store-conditional bus cycle now |
| sc_done | output | 1 | Store-conditional result pulse |
| sc_pass | output | 1 | Store-conditional succeeded (with sc_done) |
| dsi | output | 1 | Data storage exception pulse |

## Verification
If the internal pending or valid state is wrong, it shows at the ports as a store-conditional that passes when it should fail. It can also show as `resv_valid` failing to drop one or two cycles after a matching snoop. The bench therefore aims snoops at cycle 0, at cycle 1 and at later cycles, and checks `resv_valid` within two edges. A wrong held line shows only at the next snoop or store-conditional, so each line-keeping case is followed by a probing snoop. An abort that comes late would let the store complete, so `sc_abort` is sampled in the same cycle as the snoop.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_WAIT = 1'b1
    } sc_state_e;

endpackage

// File: rtl/resv_lr_stage.sv
module resv_lr_stage #(
    parameter int IDX_W = 6,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             c0_valid,
    input  logic [IDX_W-1:0] c0_index,
    input  logic [WAY_W-1:0] c0_way,
    input  logic             snp_valid,
    input  logic [IDX_W-1:0] snp_index,
    input  logic [WAY_W-1:0] snp_way,
    output logic             s1_valid,
    output logic             s1_kill
);

    typedef struct packed {
        logic valid;
        logic kill;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = c0_valid;
        st_d.kill  = c0_valid && snp_valid &&
                     (snp_index == c0_index) && (snp_way == c0_way);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s1_valid = st_q.valid;
    assign s1_kill  = st_q.kill;

    AST_KILL_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        s1_kill |-> s1_valid && $past(snp_valid)); // R3

endmodule

// File: rtl/resv_snoop_cmp.sv
module resv_snoop_cmp #(
    parameter int LINE_W = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [LINE_W-1:0] snp_line,
    input  logic [LINE_W-1:0] resv_line,
    output logic              hit_now,
    output logic              hit_prev
);

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] line;
    } held_t;

    held_t held_d, held_q;

    always_comb begin
        held_d       = held_q;
        held_d.valid = snp_valid;
        held_d.line  = snp_line;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    assign hit_now  = snp_valid && (snp_line == resv_line);
    assign hit_prev = held_q.valid && (held_q.line == resv_line);

    AST_PREV_FROM_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        hit_prev |-> $past(snp_valid)); // R4

endmodule

// File: rtl/resv_tracker.sv
module resv_tracker #(
    parameter int ADDR_W   = 40,
    parameter int LINE_OFF = 6,
    parameter int IDX_W    = 6,
    parameter int WAY_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_c0_valid,
    input  logic [IDX_W-1:0]  lr_c0_index,
    input  logic [WAY_W-1:0]  lr_c0_way,
    input  logic [ADDR_W-1:0] lr_c1_addr,
    input  logic              lr_c1_nc,
    input  logic              lr_data_valid,
    input  logic              snp_valid,
    input  logic [IDX_W-1:0]  snp_index,
    input  logic [WAY_W-1:0]  snp_way,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              sc_req,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              sc_nc,
    input  logic              sc_ack,
    output logic              resv_valid,
    output logic              sc_abort,
    output logic              sc_done,
    output logic              sc_pass,
    output logic              dsi
);
    import resv_pkg::*;

    localparam int LINE_W = ADDR_W - LINE_OFF;

    typedef struct packed {
        logic              pend;
        logic              valid;
        logic [LINE_W-1:0] line;
        sc_state_e         sc_st;
        logic              done;
        logic              pass;
        logic              dsi;
    } state_t;

    state_t s_d, s_q;

    logic s1_valid, s1_kill;
    logic hit_now, hit_prev;
    logic live, loss;

    resv_lr_stage #(.IDX_W(IDX_W), .WAY_W(WAY_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .c0_valid  (lr_c0_valid),
        .c0_index  (lr_c0_index),
        .c0_way    (lr_c0_way),
        .snp_valid (snp_valid),
        .snp_index (snp_index),
        .snp_way   (snp_way),
        .s1_valid  (s1_valid),
        .s1_kill   (s1_kill)
    );

    resv_snoop_cmp #(.LINE_W(LINE_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .snp_valid (snp_valid),
        .snp_line  (snp_addr[ADDR_W-1:LINE_OFF]),
        .resv_line (s_q.line),
        .hit_now   (hit_now),
        .hit_prev  (hit_prev)
    );

    assign live = s_q.pend || s_q.valid;
    assign loss = live && (hit_now || hit_prev);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.pass = 1'b0;
        s_d.dsi  = 1'b0;

        // snoop cancellation
        if (loss) begin
            s_d.pend  = 1'b0;
            s_d.valid = 1'b0;
        end

        // data arrival makes a pending reservation valid (first strobe only)
        if (s_q.pend && lr_data_valid && !loss) begin
            s_d.valid = 1'b1;
            s_d.pend  = 1'b0;
        end

        // end of load-reserve cycle 1
        if (s1_valid) begin
            if (lr_c1_nc) begin
                s_d.dsi = 1'b1;
            end else begin
                s_d.line  = lr_c1_addr[ADDR_W-1:LINE_OFF];
                s_d.pend  = !s1_kill;
                s_d.valid = 1'b0;
            end
        end

        // store-conditional
        if (s_q.sc_st == SC_WAIT) begin
            if (loss) begin
                s_d.sc_st = SC_IDLE;
                s_d.done  = 1'b1;
            end else if (sc_ack) begin
                s_d.sc_st = SC_IDLE;
                s_d.done  = 1'b1;
                s_d.pass  = 1'b1;
                s_d.valid = 1'b0;
                s_d.pend  = 1'b0;
            end
        end else if (sc_req) begin
            if (sc_nc) begin
                s_d.dsi = 1'b1;
            end else if (s_q.valid && !loss &&
                         (sc_addr[ADDR_W-1:LINE_OFF] == s_q.line)) begin
                s_d.sc_st = SC_WAIT;
            end else begin
                s_d.done  = 1'b1;
                s_d.valid = 1'b0;
                s_d.pend  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.sc_st <= SC_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign resv_valid = s_q.valid;
    assign sc_abort   = (s_q.sc_st == SC_WAIT) && loss;
    assign sc_done    = s_q.done;
    assign sc_pass    = s_q.pass;
    assign dsi        = s_q.dsi;

    AST_VALID_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resv_valid) |-> $past(lr_data_valid)); // R2

    AST_LOSS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        loss |=> !resv_valid); // R4

    AST_ABORT_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        sc_abort |=> sc_done && !sc_pass); // R8

    AST_PASS_DROPS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_done && sc_pass) |-> !resv_valid && $past(sc_ack)); // R6

    AST_PASS_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass |-> sc_done); // R6

endmodule

// File: tb/test_resv_tracker.sv
module test_resv_tracker;

    localparam int ADDR_W = 40;
    localparam int IDX_W  = 6;
    localparam int WAY_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              lr_c0_valid;
    logic [IDX_W-1:0]  lr_c0_index;
    logic [WAY_W-1:0]  lr_c0_way;
    logic [ADDR_W-1:0] lr_c1_addr;
    logic              lr_c1_nc;
    logic              lr_data_valid;
    logic              snp_valid;
    logic [IDX_W-1:0]  snp_index;
    logic [WAY_W-1:0]  snp_way;
    logic [ADDR_W-1:0] snp_addr;
    logic              sc_req;
    logic [ADDR_W-1:0] sc_addr;
    logic              sc_nc;
    logic              sc_ack;
    logic              resv_valid, sc_abort, sc_done, sc_pass, dsi;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    localparam logic [ADDR_W-1:0] LA = 40'h12_3456_7800;
    localparam logic [ADDR_W-1:0] LB = 40'h00_0ABC_0040;
    localparam logic [ADDR_W-1:0] LC = 40'h07_7777_0000;

    always #5 clk = ~clk;

    resv_tracker i_resv_tracker (
        .clk(clk), .rst_n(rst_n),
        .lr_c0_valid(lr_c0_valid), .lr_c0_index(lr_c0_index), .lr_c0_way(lr_c0_way),
        .lr_c1_addr(lr_c1_addr), .lr_c1_nc(lr_c1_nc), .lr_data_valid(lr_data_valid),
        .snp_valid(snp_valid), .snp_index(snp_index), .snp_way(snp_way), .snp_addr(snp_addr),
        .sc_req(sc_req), .sc_addr(sc_addr), .sc_nc(sc_nc), .sc_ack(sc_ack),
        .resv_valid(resv_valid), .sc_abort(sc_abort), .sc_done(sc_done),
        .sc_pass(sc_pass), .dsi(dsi)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        lr_c0_valid = 0; lr_c0_index = '0; lr_c0_way = '0;
        lr_c1_addr = '0; lr_c1_nc = 0; lr_data_valid = 0;
        snp_valid = 0; snp_index = '0; snp_way = '0; snp_addr = '0;
        sc_req = 0; sc_addr = '0; sc_nc = 0; sc_ack = 0;
    endtask

    task automatic snoop(input logic [ADDR_W-1:0] a);
        snp_valid = 1; snp_index = 6'd40; snp_way = 2'd3; snp_addr = a;
        tick();
        snp_valid = 0;
    endtask

    task automatic make_resv(input logic [ADDR_W-1:0] a);
        lr_c0_valid = 1; lr_c0_index = 6'd5; lr_c0_way = 2'd1;
        tick();
        lr_c0_valid = 0; lr_c1_addr = a; lr_c1_nc = 0;
        tick();
        lr_data_valid = 1;
        tick();
        lr_data_valid = 0;
    endtask

    task automatic t_reset();
        check("R1 resv_valid", resv_valid, 0);
        check("R1 sc_done", sc_done, 0);
        check("R1 dsi", dsi, 0);
        check("R1 sc_abort", sc_abort, 0);
    endtask

    task automatic t_basic_and_quad();
        lr_c0_valid = 1; lr_c0_index = 6'd5; lr_c0_way = 2'd1;
        tick();
        lr_c0_valid = 0; lr_c1_addr = LA;
        tick();
        check("R2 not valid before data", resv_valid, 0);
        lr_data_valid = 1;
        tick();
        lr_data_valid = 0;
        check("R2 valid after first strobe", resv_valid, 1);
        snp_valid = 1; snp_addr = LA + 40'h20;
        tick();
        snp_valid = 0; lr_data_valid = 1;
        tick();
        lr_data_valid = 0;
        tick();
        check("R2 second strobe no revive", resv_valid, 0);
    endtask

    task automatic t_c0_snoop(input logic [WAY_W-1:0] sway, input logic exp);
        lr_c0_valid = 1; lr_c0_index = 6'd9; lr_c0_way = 2'd2;
        snp_valid = 1; snp_index = 6'd9; snp_way = sway; snp_addr = LC;
        tick();
        lr_c0_valid = 0; snp_valid = 0; lr_c1_addr = LA;
        tick();
        lr_data_valid = 1;
        tick();
        lr_data_valid = 0;
        check("R3 cycle-0 index/way snoop", resv_valid, 32'(exp));
    endtask

    task automatic t_c1_snoop();
        lr_c0_valid = 1; lr_c0_index = 6'd5; lr_c0_way = 2'd1;
        tick();
        lr_c0_valid = 0; lr_c1_addr = LA;
        snp_valid = 1; snp_addr = LA + 40'h8;
        tick();
        snp_valid = 0; lr_data_valid = 1;
        tick();
        lr_data_valid = 0;
        check("R4 cycle-1 snoop via held copy", resv_valid, 0);
    endtask

    task automatic t_late_snoop();
        make_resv(LA);
        snoop(LA + 40'h40);
        tick();
        check("R5 other line keeps", resv_valid, 1);
        snoop(LA + 40'h3F);
        check("R4 R5 same line offset clears", resv_valid, 0);
    endtask

    task automatic t_sc_pass();
        make_resv(LA);
        sc_req = 1; sc_addr = LA + 40'h4;
        tick();
        sc_req = 0;
        check("R6 waiting no done", sc_done, 0);
        sc_ack = 1;
        tick();
        sc_ack = 0;
        check("R6 done", sc_done, 1);
        check("R6 pass", sc_pass, 1);
        check("R6 resv cleared", resv_valid, 0);
    endtask

    task automatic t_sc_fail();
        sc_req = 1; sc_addr = LA;
        tick();
        sc_req = 0;
        check("R7 no resv done", sc_done, 1);
        check("R7 no resv fail", sc_pass, 0);
        make_resv(LA);
        sc_req = 1; sc_addr = LB;
        tick();
        sc_req = 0;
        check("R7 mismatch fail", {sc_done, sc_pass}, 2'b10);
        check("R7 mismatch clears", resv_valid, 0);
    endtask

    task automatic t_sc_abort();
        make_resv(LA);
        sc_req = 1; sc_addr = LA;
        tick();
        sc_req = 0;
        snp_valid = 1; snp_addr = LA + 40'h10;
        #1;
        check("R8 abort same cycle", sc_abort, 1);
        tick();
        snp_valid = 0;
        check("R8 done fail", {sc_done, sc_pass}, 2'b10);
        check("R8 resv cleared", resv_valid, 0);
    endtask

    task automatic t_nc();
        make_resv(LA);
        lr_c0_valid = 1; lr_c0_index = 6'd7; lr_c0_way = 2'd0;
        tick();
        lr_c0_valid = 0; lr_c1_addr = LB; lr_c1_nc = 1;
        tick();
        lr_c1_nc = 0;
        check("R9 lr nc dsi", dsi, 1);
        check("R9 lr nc keeps resv", resv_valid, 1);
        snoop(LB);
        tick();
        check("R9 line not replaced", resv_valid, 1);
        sc_req = 1; sc_nc = 1; sc_addr = LA;
        tick();
        sc_req = 0; sc_nc = 0;
        check("R9 sc nc dsi", dsi, 1);
        check("R9 sc nc no done", sc_done, 0);
        check("R9 sc nc keeps resv", resv_valid, 1);
        snoop(LA);
        check("R9 kept line is old", resv_valid, 0);
    endtask

    task automatic t_replace();
        make_resv(LA);
        make_resv(LB);
        snoop(LA);
        tick();
        check("R10 old line ignored", resv_valid, 1);
        snoop(LB);
        check("R10 new line clears", resv_valid, 0);
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_basic_and_quad();
        t_c0_snoop(2'd2, 1'b0);
        t_c0_snoop(2'd3, 1'b1);
        t_c1_snoop();
        t_late_snoop();
        t_sc_pass();
        t_sc_fail();
        t_sc_abort();
        t_nc();
        t_replace();
        tick();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule